// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column addresses of a single SDRAM burst, one beat at a time. A controller or a memory model starts it with the starting column, the burst length code and the wrap type. It then steps it once per data beat with an advance enable. The block gives the column of the current beat, a valid flag, and a flag that marks the final beat of a fixed-length burst.

The block has two states. ST_IDLE means no burst is running and the valid flag is low. ST_BURST means a burst is running and the valid flag is high. The transitions are named as follows. START goes from any state to ST_BURST, loads the new burst and has the highest priority. TERM goes from ST_BURST to ST_IDLE when the terminate input is high. FINISH goes from ST_BURST to ST_IDLE when the final beat of a fixed-length burst is advanced. STEP stays in ST_BURST and moves to the next beat. HOLD stays in the current state when the advance enable is low.

A fixed-length burst stays inside an aligned block of its own length. A full-page burst runs over all columns and continues until it is terminated.

Top module: `bcol_gen`

## Requirements
- R1: After reset, o_valid and o_last are 0.
- R2: One cycle after i_start is high at a clock edge, o_valid is 1 and o_col equals the i_col sampled at that edge. That column is beat 0.
- R3: Length codes are 3'b001 = 2, 3'b010 = 4 and 3'b011 = 8 beats. With i_ilv = 0 and one of these codes, the low log2(BL) bits of beat n are (start + n) mod BL. The upper bits keep their start value.
- R4: With i_ilv = 1 and length 2, 4 or 8, the low log2(BL) bits of beat n are the start's low bits XOR n. The upper bits keep their start value.
- R5: Code 3'b000, and the unused codes 3'b100, 3'b101 and 3'b110, give a single-beat burst. Its only beat is at the start column, and o_last is 1 on that beat.
- R6: In a fixed-length burst, o_last is 1 only on beat BL-1. Advancing on that beat drops o_valid on the next cycle.
- R7: Code 3'b111 selects full page. The column rises by one per advance and wraps from 511 to 0. o_last is never set, and the burst runs until it is terminated or restarted. Full page with i_ilv = 1 behaves as sequential full page.
- R8: When i_term is high and i_start is low, o_valid is 0 on the next cycle.
- R9: i_start during a running burst restarts the sequence at the new column, beat 0, with the new length and wrap type.
- R10: While a burst runs and i_adv, i_start and i_term are all low, o_col and o_valid hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| i_start | input | 1 | Start strobe; loads a new burst |
| i_col | input | 9 | Starting column |
| i_len | input | 3 | Burst length code |
| i_ilv | input | 1 | 1 = interleave wrap, 0 = sequential wrap |
| i_adv | input | 1 | Advance to the next beat |
| i_term | input | 1 | Terminate the running burst |
| o_col | output | 9 | Column of the current beat |
| o_valid | output | 1 | A burst beat is being presented |
| o_last | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The bench first targets wrap at the block edge: a sequential burst that starts partway into its block must come back to the block's base, not carry into the upper bits. It also targets interleave order, where a design that adds instead of XORs gives the wrong order whenever the start is not aligned. For full page, the bench checks the wrap from 511 to 0 and checks that full page with interleave selected still counts up; a faulty design would stop, set the last flag, or jump around. Finally, it checks that start takes priority over terminate and that an idle advance holds the column.

// File: rtl/bcol_pkg.sv
package bcol_pkg;
    typedef enum logic [2:0] {
        LEN_1    = 3'b000,
        LEN_2    = 3'b001,
        LEN_4    = 3'b010,
        LEN_8    = 3'b011,
        LEN_PAGE = 3'b111
    } len_code_e;

    typedef enum logic {
        ST_IDLE,
        ST_BURST
    } bst_e;
endpackage

// File: rtl/bcol_mask_dec.sv
module bcol_mask_dec
    import bcol_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [2:0]       len_code,
    output logic [COL_W-1:0] blk_mask,
    output logic             page_mode
);
    always_comb begin
        page_mode = (len_code == LEN_PAGE);
        case (len_code)
            LEN_2:    blk_mask = COL_W'(1);
            LEN_4:    blk_mask = COL_W'(3);
            LEN_8:    blk_mask = COL_W'(7);
            LEN_PAGE: blk_mask = '1;
            default:  blk_mask = '0;
        endcase
    end
endmodule

// File: rtl/bcol_addr_calc.sv
module bcol_addr_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] blk_mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    always_comb begin
        low_seq = base + beat;
        low_ilv = base ^ beat;
        col = (base & ~blk_mask) | ((ilv ? low_ilv : low_seq) & blk_mask);
    end
endmodule

// File: rtl/bcol_gen.sv
module bcol_gen
    import bcol_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_start,
    input  logic [COL_W-1:0] i_col,
    input  logic [2:0]       i_len,
    input  logic             i_ilv,
    input  logic             i_adv,
    input  logic             i_term,
    output logic [COL_W-1:0] o_col,
    output logic             o_valid,
    output logic             o_last
);
    localparam logic [COL_W-1:0] BEAT_ONE = COL_W'(1);

    bst_e             state_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [2:0]       len_q;
    logic             ilv_q;
    logic [COL_W-1:0] blk_mask;
    logic             page_mode;
    logic             last_hit;
    logic [COL_W-1:0] calc_col;

    bcol_mask_dec #(.COL_W(COL_W)) u_mask (
        .len_code  (len_q),
        .blk_mask  (blk_mask),
        .page_mode (page_mode)
    );

    bcol_addr_calc #(.COL_W(COL_W)) u_calc (
        .base     (base_q),
        .beat     (beat_q),
        .blk_mask (blk_mask),
        .ilv      (ilv_q),
        .col      (calc_col)
    );

    assign last_hit = !page_mode && (beat_q == blk_mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            len_q   <= LEN_1;
            ilv_q   <= 1'b0;
        end else if (i_start) begin
            state_q <= ST_BURST;
            base_q  <= i_col;
            beat_q  <= '0;
            len_q   <= i_len;
            ilv_q   <= i_ilv && (i_len != LEN_PAGE);
        end else begin
            unique case (state_q)
                ST_IDLE: state_q <= ST_IDLE;
                ST_BURST: begin
                    if (i_term) begin
                        state_q <= ST_IDLE;
                    end else if (i_adv) begin
                        if (last_hit) state_q <= ST_IDLE;
                        else          beat_q  <= beat_q + BEAT_ONE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        o_valid = (state_q == ST_BURST);
        o_last  = o_valid && last_hit;
        o_col   = calc_col;
    end

    // R6
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_last |-> o_valid);
    // R6
    finish_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_last && i_adv && !i_start && !i_term) |=> !o_valid);
    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i_start |=> (o_valid && o_col == $past(i_col)));
    // R8
    term_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_term && !i_start) |=> !o_valid);
    // R10
    hold_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !i_adv && !i_start && !i_term) |=> (o_valid && $stable(o_col)));
    // R7
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && page_mode && i_adv && !i_start && !i_term)
            |=> (o_valid && !o_last && o_col == $past(o_col) + BEAT_ONE));
endmodule

// File: tb/sim_bcol_gen.sv
module sim_bcol_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       i_start, i_ilv, i_adv, i_term;
    logic [8:0] i_col;
    logic [2:0] i_len;
    logic [8:0] o_col;
    logic       o_valid, o_last;

    int n_cmp = 0;
    int n_bad = 0;

    bit       m_act = 0;
    bit [8:0] m_start = 0;
    bit [8:0] m_n = 0;
    bit [2:0] m_code = 0;
    bit       m_ilv = 0;

    always #10 clk = ~clk;

    bcol_gen u0 (
        .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_col(i_col),
        .i_len(i_len), .i_ilv(i_ilv), .i_adv(i_adv), .i_term(i_term),
        .o_col(o_col), .o_valid(o_valid), .o_last(o_last)
    );

    function automatic int f_len(bit [2:0] c);
        case (c)
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 512;
            default: return 1;
        endcase
    endfunction

    function automatic bit [8:0] f_col(bit [8:0] s, bit [8:0] n, bit [2:0] c, bit iv);
        bit [8:0] m = 9'(f_len(c) - 1);
        bit [8:0] lo = (iv && c != 3'b111) ? (s ^ n) : 9'(s + n);
        return (s & ~m) | (lo & m);
    endfunction

    function automatic string f_tag();
        if (m_code == 3'b111) return "R7";
        if (f_len(m_code) == 1) return "R5";
        if (m_ilv) return "R4";
        return "R3";
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(bit st, bit [8:0] c, bit [2:0] l, bit iv, bit adv, bit tm, string tag);
        bit e_last;
        @(negedge clk);
        i_start = st; i_col = c; i_len = l; i_ilv = iv; i_adv = adv; i_term = tm;
        @(posedge clk);
        if (st) begin
            m_act = 1; m_start = c; m_n = 0; m_code = l; m_ilv = iv;
        end else if (tm) begin
            m_act = 0;
        end else if (m_act && adv) begin
            if (m_code != 3'b111 && int'(m_n) == f_len(m_code) - 1) m_act = 0;
            else m_n = m_n + 9'd1;
        end
        #5;
        chk((tag != "") ? tag : "R8", int'(o_valid), int'(m_act));
        if (m_act) begin
            chk((tag != "") ? tag : f_tag(), int'(o_col), int'(f_col(m_start, m_n, m_code, m_ilv)));
            e_last = (m_code != 3'b111) && (int'(m_n) == f_len(m_code) - 1);
            chk((tag != "") ? tag : "R6", int'(o_last), int'(e_last));
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; i_start = 0; i_col = 0; i_len = 0; i_ilv = 0; i_adv = 0; i_term = 0;
        repeat (3) @(posedge clk);
        #5;
        chk("R1", int'(o_valid), 0);
        chk("R1", int'(o_last), 0);
        @(negedge clk) rst_n = 1;

        // R2 first beat, R3 sequential len 8 from 13: 13,14,15,8..12
        step(1, 9'd13, 3'b011, 0, 0, 0, "R2");
        chk("R2", int'(o_col), 13);
        for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 1, 0, "");
        // R4 interleave len 4 from 6: 6,7,4,5
        step(1, 9'd6, 3'b010, 1, 0, 0, "R4");
        step(0, 0, 0, 0, 1, 0, "R4");
        step(0, 0, 0, 0, 1, 0, "R4");
        chk("R4", int'(o_col), 4);
        step(0, 0, 0, 0, 1, 0, "R4");
        step(0, 0, 0, 0, 1, 0, "R6");
        // R5 single beat, including an unused code
        step(1, 9'd77, 3'b000, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 0, "R5");
        step(1, 9'd90, 3'b101, 1, 0, 0, "R5");
        chk("R5", int'(o_last), 1);
        step(0, 0, 0, 0, 1, 0, "R5");
        // R7 full page with interleave, wrap 511 -> 0
        step(1, 9'd510, 3'b111, 1, 0, 0, "R7");
        for (int k = 0; k < 520; k++) step(0, 0, 0, 0, 1, 0, "R7");
        // R10 hold
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, "R10");
        // R9 restart mid burst
        step(1, 9'd33, 3'b010, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 1, 0, "R9");
        step(1, 9'd200, 3'b001, 1, 1, 1, "R9");
        chk("R9", int'(o_col), 200);
        // R8 terminate
        step(0, 0, 0, 0, 1, 1, "R8");
        chk("R8", int'(o_valid), 0);

        for (int k = 0; k < 4000; k++) begin
            bit [2:0] l = 3'($urandom_range(0, 7));
            bit st = ($urandom_range(0, m_act ? 15 : 3) == 0);
            step(st, 9'($urandom_range(0, 511)), l, 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 3) != 0), ($urandom_range(0, 31) == 0), "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule